// File: doc/BRIEF.md
# Clocked Burst Read Sequencer

This block is the synchronous read path of a flash memory model, used while burst mode is on. The host pulses a load strobe with a start address on the bus. The sequencer then waits a fixed number of clock cycles for the first access. After that it steps through a fixed-length block of sequential words, one per clock, whenever the host pulls its advance strobe low. The words come from an array read port that the sequencer addresses. An active-low end marker is shown together with the final word.

The burst is 32 words long. The word offset wraps inside an aligned 32-word block, and the upper address bits stay fixed for the whole burst. The load strobe must be seen high on the clock edge after the load edge. If it is not, the sequencer raises a one-cycle error pulse and goes idle without delivering any data. While the burst-mode flag is clear, the sequencer ignores both strobes and holds its outputs.

Top module: `burst_rd_engine`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `end_n` is 1, `proto_err` is 0 and `arr_addr` is 0.
- R2: A rising edge with `burst_on`=1 and `load_n`=0 latches `start_addr` as the burst start. The word at that address appears on `rd_data` exactly LAT (default 3) rising edges after the load edge. Until then, `rd_data` keeps its previous value.
- R3: After the first word, each rising edge with `adv_n`=0 presents the next sequential word, `arr_data` taken at the next address.
- R4: On a rising edge with `adv_n`=1 during a burst, `rd_data` and `end_n` hold their values.
- R5: Word i of a burst (i = 0..31) is read from the address whose bits [AW-1:5] equal those of the start address and whose bits [4:0] equal (start[4:0] + i) mod 32.
- R6: `end_n` is 0 exactly while the 32nd word is on `rd_data`, and 1 for every earlier word.
- R7: On the edge after the 32nd word, `end_n` returns to 1 and the sequencer goes idle. Further `adv_n`=0 edges leave `rd_data` unchanged until a new load.
- R8: If `load_n` is still 0 on the edge after a load, `proto_err` is 1 for exactly one cycle after that edge, no word is delivered, and `rd_data` holds.
- R9: While `burst_on`=0, loads and advances have no effect: `rd_data` holds and `end_n` is 1. Clearing `burst_on` mid-burst aborts the burst, so advances after re-enable do nothing until a new load.
- R10: A load accepted in the middle of a burst restarts the sequence. The previous word holds until the new start word appears LAT edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| burst_on | input | 1 | Burst mode flag; sequencer inactive when 0 |
| load_n | input | 1 | Active-low start-address load strobe |
| adv_n | input | 1 | Active-low advance strobe |
| start_addr | input | AW | Start address sampled on the load edge |
| arr_addr | output | AW | Registered address to the array read port |
| arr_data | input | DW | Combinational data from the array read port |
| rd_data | output | DW | Registered burst data word |
| end_n | output | 1 | Active-low last-word marker |
| proto_err | output | 1 | One-cycle pulse on a load strobe held too long |

## Verification
The bench sweeps every start offset inside two different address blocks, so offset wrap is exercised. A design that carried into the upper address bits, or that reset the offset to zero, would read the wrong words. Stalls placed at varying positions would expose a sequencer that advances with `adv_n` high. The cycle just before the first word would expose a latency that is off by one. The end marker is checked on every word and on the edge after the burst: a marker that is early, late or stuck low, or a sequencer that keeps stepping past 32 words, would fail there. Held load strobes, a cleared mode flag and a reload in mid-burst target a design that delivers data after an error, obeys strobes while disabled, or finishes the old burst instead of restarting.

// File: rtl/brst_pkg.sv
package brst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_STREAM = 2'd3
  } brst_state_t;
endpackage

// File: rtl/brst_ctrl.sv
module brst_ctrl
  import brst_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_on,
  input  logic load_n,
  input  logic adv_n,
  input  logic burst_full,
  output logic take_load,
  output logic take_step,
  output logic err_q
);
  localparam int LCW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [LCW-1:0] LSTART = LCW'(LAT - 2);

  brst_state_t st;
  logic [LCW-1:0] lcnt;

  // A load is accepted anywhere except in the check cycle, where a low strobe is an error.
  always_comb begin
    take_load = burst_on && !load_n && (st != ST_CHECK);
    take_step = burst_on && !take_load &&
                (((st == ST_WAIT) && (lcnt == '0)) ||
                 ((st == ST_STREAM) && !adv_n && !burst_full));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      lcnt  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!burst_on) begin
        st <= ST_IDLE;
      end else if (st == ST_CHECK) begin
        if (!load_n) begin
          err_q <= 1'b1;
          st    <= ST_IDLE;
        end else begin
          st   <= ST_WAIT;
          lcnt <= LSTART;
        end
      end else if (take_load) begin
        st <= ST_CHECK;
      end else begin
        case (st)
          ST_WAIT: begin
            if (lcnt == '0) st <= ST_STREAM;
            else            lcnt <= lcnt - 1'b1;
          end
          ST_STREAM: begin
            if (burst_full) st <= ST_IDLE;
          end
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/brst_addr.sv
module brst_addr #(
  parameter int AW   = 16,
  parameter int BLEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_load,
  input  logic          take_step,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] ptr_q,
  output logic          burst_full,
  output logic          near_last
);
  localparam int OFFW = $clog2(BLEN);
  localparam int CW   = OFFW + 1;
  localparam logic [CW-1:0] CFULL = CW'(BLEN);
  localparam logic [CW-1:0] CLAST = CW'(BLEN - 1);

  logic [CW-1:0]   wcnt;
  logic [OFFW-1:0] off_nxt;

  assign off_nxt    = ptr_q[OFFW-1:0] + 1'b1;
  assign burst_full = (wcnt == CFULL);
  assign near_last  = (wcnt == CLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      wcnt  <= '0;
    end else if (take_load) begin
      ptr_q <= start_addr;
      wcnt  <= '0;
    end else if (take_step) begin
      ptr_q <= {ptr_q[AW-1:OFFW], off_nxt};
      wcnt  <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/brst_out.sv
module brst_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_step,
  input  logic          near_last,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          end_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      end_n   <= 1'b1;
    end else begin
      if (take_step) rd_data <= arr_data;
      end_n <= !(take_step && near_last);
    end
  end
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int BLEN = 32,
  parameter int LAT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst_on,
  input  logic          load_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          end_n,
  output logic          proto_err
);
  logic take_load, take_step, burst_full, near_last;

  brst_ctrl #(.LAT(LAT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .burst_on   (burst_on),
    .load_n     (load_n),
    .adv_n      (adv_n),
    .burst_full (burst_full),
    .take_load  (take_load),
    .take_step  (take_step),
    .err_q      (proto_err)
  );

  brst_addr #(.AW(AW), .BLEN(BLEN)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .take_load  (take_load),
    .take_step  (take_step),
    .start_addr (start_addr),
    .ptr_q      (arr_addr),
    .burst_full (burst_full),
    .near_last  (near_last)
  );

  brst_out #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .take_step (take_step),
    .near_last (near_last),
    .arr_data  (arr_data),
    .rd_data   (rd_data),
    .end_n     (end_n)
  );
endmodule

// File: rtl/brst_chk.sv
module brst_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          burst_on,
  input logic          load_n,
  input logic [DW-1:0] rd_data,
  input logic          end_n,
  input logic          proto_err
);
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(!load_n) && $past(burst_on)));

  p_end_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !end_n |=> end_n);

  p_off_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !burst_on |=> ($stable(rd_data) && end_n && !proto_err));
endmodule

bind burst_rd_engine brst_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .burst_on  (burst_on),
  .load_n    (load_n),
  .rd_data   (rd_data),
  .end_n     (end_n),
  .proto_err (proto_err)
);

// File: tb/sim_burst_rd_engine.sv
module sim_burst_rd_engine;
  localparam int AW = 16, DW = 16, BLEN = 32, LAT = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic burst_on = 1'b1, load_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data, rd_data;
  logic end_n, proto_err;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] prev = '0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] f(input logic [AW-1:0] a);
    return DW'(a * 16'd7 + 16'h1357);
  endfunction

  function automatic logic [AW-1:0] waddr(input logic [AW-1:0] s, input int i);
    logic [4:0] o;
    o = s[4:0] + 5'(i);
    return {s[AW-1:5], o};
  endfunction

  assign arr_data = f(arr_addr);

  burst_rd_engine #(.AW(AW), .DW(DW), .BLEN(BLEN), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .burst_on(burst_on), .load_n(load_n), .adv_n(adv_n),
    .start_addr(start_addr), .arr_addr(arr_addr), .arr_data(arr_data),
    .rd_data(rd_data), .end_n(end_n), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Load start address; returns at the negedge after the check edge.
  task automatic do_load(input logic [AW-1:0] a);
    load_n = 1'b0; start_addr = a;
    nx(1);
    load_n = 1'b1; start_addr = ~a;
    nx(1);
  endtask

  task automatic first_word(input logic [AW-1:0] a);
    do_load(a);
    nx(LAT - 2);
    chk(rd_data == prev, "R2 hold before first word", rd_data, prev);
    nx(1);
    chk(rd_data == f(a), "R2 first word", rd_data, f(a));
    chk(end_n == 1'b1, "R6 end_n high on first word", end_n, 1);
  endtask

  task automatic burst(input logic [AW-1:0] a, input int stall);
    logic [DW-1:0] e;
    first_word(a);
    for (int i = 1; i < BLEN; i++) begin
      if (stall != 0 && (i % stall) == 0) begin
        adv_n = 1'b1;
        nx(1);
        e = f(waddr(a, i - 1));
        chk(rd_data == e, "R4 hold on stall", rd_data, e);
        chk(end_n == 1'b1, "R4 end_n held on stall", end_n, 1);
      end
      adv_n = 1'b0;
      nx(1);
      e = f(waddr(a, i));
      chk(rd_data == e, "R3 R5 sequential word", rd_data, e);
      chk(end_n == (i == BLEN - 1 ? 1'b0 : 1'b1), "R6 end_n marker", end_n, (i == BLEN - 1) ? 0 : 1);
    end
    e = f(waddr(a, BLEN - 1));
    nx(1);
    chk(end_n == 1'b1, "R7 end_n released", end_n, 1);
    chk(rd_data == e, "R7 idle after burst", rd_data, e);
    nx(2);
    chk(rd_data == e, "R7 no step past burst", rd_data, e);
    adv_n = 1'b1;
    prev = e;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    nx(3);
    chk(rd_data == '0, "R1 rd_data reset", rd_data, 0);
    chk(end_n == 1'b1, "R1 end_n reset", end_n, 1);
    chk(proto_err == 1'b0, "R1 proto_err reset", proto_err, 0);
    chk(arr_addr == '0, "R1 arr_addr reset", arr_addr, 0);
    rst = 1'b0;
    nx(1);

    // Sweep all start offsets in two blocks with varied stall spacing
    for (int b = 0; b < 2; b++) begin
      for (int o = 0; o < BLEN; o++) begin
        burst(AW'(b == 0 ? 16'h0000 : 16'hBEE0) | AW'(o), (o % 3 == 0) ? 0 : (o % 7) + 2);
      end
    end

    // R8: load strobe held for two edges
    load_n = 1'b0; start_addr = 16'h4321;
    nx(2);
    load_n = 1'b1;
    chk(proto_err == 1'b1, "R8 error pulse", proto_err, 1);
    nx(1);
    chk(proto_err == 1'b0, "R8 error one cycle", proto_err, 0);
    adv_n = 1'b0;
    nx(LAT + 4);
    chk(rd_data == prev, "R8 no data after error", rd_data, prev);
    chk(end_n == 1'b1, "R8 end_n high", end_n, 1);
    adv_n = 1'b1;

    // R9: flag cleared, strobes ignored
    burst_on = 1'b0;
    do_load(16'h1200);
    adv_n = 1'b0;
    nx(LAT + 6);
    chk(rd_data == prev, "R9 load ignored when off", rd_data, prev);
    chk(end_n == 1'b1, "R9 end_n high when off", end_n, 1);
    adv_n = 1'b1;
    burst_on = 1'b1;

    // R9: abort mid-burst
    first_word(16'h2207);
    adv_n = 1'b0;
    nx(4);
    chk(rd_data == f(waddr(16'h2207, 4)), "R9 pre-abort word", rd_data, f(waddr(16'h2207, 4)));
    burst_on = 1'b0;
    nx(3);
    chk(rd_data == f(waddr(16'h2207, 4)), "R9 hold while off", rd_data, f(waddr(16'h2207, 4)));
    burst_on = 1'b1;
    nx(3);
    chk(rd_data == f(waddr(16'h2207, 4)), "R9 no resume after re-enable", rd_data, f(waddr(16'h2207, 4)));
    prev = f(waddr(16'h2207, 4));
    adv_n = 1'b1;

    // R10: reload in mid-burst with advance held low
    first_word(16'h3319);
    adv_n = 1'b0;
    nx(5);
    prev = f(waddr(16'h3319, 5));
    chk(rd_data == prev, "R10 old burst word", rd_data, prev);
    burst(16'h7A1C, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule